// File: doc/BRIEF.md
# Retriggerable One-Pulse PWM Timer

This block is a 12-bit up-counter with auto-reload that drives two PWM outputs from a single shared time base. Each output is high from a counter restart until the counter reaches that channel's compare value, and low for the rest of the period. The block runs in one of two ways. In plain PWM mode it is a free-running timer. In one-pulse mode an external trigger input can also restart the period.

In one-pulse mode, the trigger is synchronized and edge-detected on its way in. An active edge restarts the counter and raises the outputs, but only once the counter has passed the compare point of the arming channel. Edges that arrive earlier are dropped. Without further edges the timer keeps running as periodic PWM.

Duty and polarity values are written to preload registers. They are copied to the active set at a counter restart while transfer is enabled, or at once by a force-update command. A break input overrides everything else: it clears the counter, the reload value and both duty registers.

Top module: `opm_pwm_timer`

## Requirements
- R1: With run set (CTRL bit 0), the counter steps by one per clock from 0 up to the reload value (address 0), then returns to 0. A period is reload+1 cycles.
- R2: Each raw output is high while the counter is below that channel's active duty value and low otherwise. Channel 0 duty preload is at address 1 and channel 1 duty preload is at address 2. A duty above the reload value keeps the output high for the whole period.
- R3: The overflow output is high for exactly one cycle, the cycle in which the counter reads 0 after a restart. A restart can come from a reload match, an accepted trigger edge or a forced overflow.
- R4: In one-pulse mode (CTRL bit 1), an accepted active trigger edge restarts the counter and drives both raw outputs high. The trigger is driven between clock edges, and the counter reads 0 after the third rising clock edge that follows the trigger change.
- R5: An active trigger edge that is detected while the counter is below the active duty of channel 1 (the arming channel) is ignored, and counting continues.
- R6: CTRL bit 2 selects the active trigger edge: 1 for rising, 0 for falling. The other edge has no effect. A change to this bit takes effect at once.
- R7: In one-pulse mode, the active polarity bit of a channel inverts its output. Channel 0's polarity preload is CTRL bit 4 and channel 1's is CTRL bit 5. In plain PWM mode polarity has no effect.
- R8: Duty and polarity preloads are copied to the active set at a counter restart only while transfer (CTRL bit 3) is set. Writing 1 to bit 0 of the command register (address 4) copies them at once.
- R9: Writing 1 to bit 1 of the command register while running restarts the counter at the next clock edge and raises the overflow flag.
- R10: While break is high, the counter, the reload value and both duty registers (preload and active) are cleared. Both outputs are inactive and no overflow is raised, even when a forced overflow is requested in the same cycle.
- R11: With run cleared, the counter holds its value, no overflow is raised, and each output sits at its inactive level. The inactive level is the active polarity bit in one-pulse mode and 0 in plain PWM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 reload, 1..2 duty, 3 control, 4 command |
| wr_data | input | 12 | Register write data |
| trig_i | input | 1 | Asynchronous external trigger |
| brk_i | input | 1 | Break, overrides all other events |
| pwm_o | output | 2 | PWM outputs, one bit per channel |
| ovf_o | output | 1 | One-cycle counter restart flag |
| cnt_o | output | 12 | Current counter value |

## Verification
The bench builds the block with its defaults: a 12-bit counter, two channels and channel 1 as the arming channel. Because the reload value is programmable, short periods (down to a reload of 0) are in reach in a few cycles, so the table covers whole periods, duty-above-reload and the single-cycle period.

The directed part programs a 20-count period. This lets the trigger be placed on either side of the arming compare point and lets the three-edge restart latency be counted exactly. It also covers the priority of break over a forced overflow in the same cycle.

// File: rtl/opm_pkg.sv
// Package: shared constants and types of the one-pulse PWM timer.
// Assumes the control register fits into the data word (4 + channels <= width).
package opm_pkg;
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_OPM  = 1;
    localparam int CTRL_RISE = 2;
    localparam int CTRL_XFER = 3;
    localparam int CTRL_POL0 = 4;
    localparam int CMD_FUPD  = 0;
    localparam int CMD_FOVF  = 1;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_TRIG  = 2'd1,
        CAUSE_FORCE = 2'd2,
        CAUSE_WRAP  = 2'd3
    } restart_cause_e;
endpackage

// File: rtl/opm_regs.sv
// Module: register file of the timer. Holds reload, duty preloads and control
// bits, and decodes the command strobes. Break clears reload and duty preloads.
// Assumes writes are single-cycle strobes and that wr_data is wide enough for CTRL.
module opm_regs #(
    parameter int CNT_W  = 12,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic                         brk,
    output logic [CNT_W-1:0]             reload,
    output logic [NUM_CH-1:0][CNT_W-1:0] duty_pre,
    output logic [NUM_CH-1:0]            pol_pre,
    output logic                         run,
    output logic                         opm_en,
    output logic                         rise_sel,
    output logic                         xfer_en,
    output logic                         force_upd,
    output logic                         force_ovf
);
    import opm_pkg::*;

    localparam int CTRL_W    = CTRL_POL0 + NUM_CH;
    localparam int A_RELOAD  = 0;
    localparam int A_DUTY0   = 1;
    localparam int A_CTRL    = A_DUTY0 + NUM_CH;
    localparam int A_CMD     = A_CTRL + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic              cmd_hit;

    // Decode a write to the command register.
    assign cmd_hit   = wr_en && (wr_addr == ADDR_W'(A_CMD));
    assign force_upd = cmd_hit && wr_data[CMD_FUPD];
    assign force_ovf = cmd_hit && wr_data[CMD_FOVF];

    // Reload register, cleared by break.
    always_ff @(posedge clk) begin
        if (!rst_n || brk)
            reload <= '0;
        else if (wr_en && wr_addr == ADDR_W'(A_RELOAD))
            reload <= wr_data;
    end

    // Control register; break leaves it untouched.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(A_CTRL))
            ctrl_q <= wr_data[CTRL_W-1:0];
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_duty
            // Duty preload of one channel, cleared by break.
            always_ff @(posedge clk) begin
                if (!rst_n || brk)
                    duty_pre[ch] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(A_DUTY0 + ch))
                    duty_pre[ch] <= wr_data;
            end
            assign pol_pre[ch] = ctrl_q[CTRL_POL0 + ch];
        end
    endgenerate

    assign run      = ctrl_q[CTRL_RUN];
    assign opm_en   = ctrl_q[CTRL_OPM];
    assign rise_sel = ctrl_q[CTRL_RISE];
    assign xfer_en  = ctrl_q[CTRL_XFER];
endmodule

// File: rtl/opm_trig_sync.sv
// Module: two-flop synchronizer and edge detector for the external trigger.
// The selected edge gives a one-cycle pulse, only while detection is enabled.
// Assumes trig_i may change at any time relative to clk.
module opm_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic det_en,
    input  logic rise_sel,
    output logic edge_o
);
    logic s1_q, s2_q, s3_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= trig_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Select the active edge; the select bit acts without delay.
    always_comb begin
        if (!det_en)
            edge_o = 1'b0;
        else if (rise_sel)
            edge_o = s2_q && !s3_q;
        else
            edge_o = !s2_q && s3_q;
    end
endmodule

// File: rtl/opm_counter.sv
// Module: shared 12-bit up-counter with auto-reload and restart arbitration.
// Priority: break, accepted trigger, forced overflow, reload match, count.
// Assumes trig_acc is already qualified by mode and arming.
module opm_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             brk,
    input  logic [CNT_W-1:0] reload,
    input  logic             trig_acc,
    input  logic             force_ovf,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q,
    output logic             restart
);
    import opm_pkg::*;

    restart_cause_e cause;

    // Resolve the restart source in fixed priority order.
    always_comb begin
        if (trig_acc)
            cause = CAUSE_TRIG;
        else if (force_ovf)
            cause = CAUSE_FORCE;
        else if (cnt_q == reload)
            cause = CAUSE_WRAP;
        else
            cause = CAUSE_NONE;
    end

    assign restart = run && !brk && (cause != CAUSE_NONE);

    // Counter state and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || brk) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (!run) begin
            ovf_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            ovf_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            ovf_q <= 1'b0;
        end
    end
endmodule

// File: rtl/opm_chan.sv
// Module: one PWM channel: active duty/polarity shadow, compare and output.
// Output is high while the counter is below duty, inverted in one-pulse mode
// by the active polarity; inactive level while stopped or in break.
module opm_chan #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk,
    input  logic             load,
    input  logic [CNT_W-1:0] duty_pre,
    input  logic             pol_pre,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run,
    input  logic             opm_en,
    output logic [CNT_W-1:0] duty_act,
    output logic             pwm_o
);
    logic pol_act;
    logic inv;

    // Active duty shadow; break clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || brk)
            duty_act <= '0;
        else if (load)
            duty_act <= duty_pre;
    end

    // Active polarity shadow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_act <= 1'b0;
        else if (load && !brk)
            pol_act <= pol_pre;
    end

    assign inv = opm_en && pol_act;

    // Output level from compare, mode and polarity.
    always_comb begin
        if (brk || !run)
            pwm_o = inv;
        else
            pwm_o = (cnt < duty_act) ^ inv;
    end
endmodule

// File: rtl/opm_pwm_timer.sv
// Module: top of the retriggerable one-pulse PWM timer.
// Ties register file, trigger front end, counter and channels together.
// Assumes ARM_CH names the channel whose compare point arms retriggering.
module opm_pwm_timer #(
    parameter int CNT_W  = 12,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3,
    parameter int ARM_CH = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              trig_i,
    input  logic              brk_i,
    output logic [NUM_CH-1:0] pwm_o,
    output logic              ovf_o,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [CNT_W-1:0]             reload;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_pre;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_act;
    logic [NUM_CH-1:0]            pol_pre;
    logic run, opm_en, rise_sel, xfer_en, force_upd, force_ovf;
    logic trig_edge, trig_acc, armed, restart, shadow_load;
    logic [CNT_W-1:0] cnt;

    opm_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .brk(brk_i), .reload(reload), .duty_pre(duty_pre),
        .pol_pre(pol_pre), .run(run), .opm_en(opm_en), .rise_sel(rise_sel),
        .xfer_en(xfer_en), .force_upd(force_upd), .force_ovf(force_ovf)
    );

    opm_trig_sync u_trig (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
        .det_en(run && opm_en), .rise_sel(rise_sel), .edge_o(trig_edge)
    );

    // Retrigger is armed once the arming channel's compare point is reached.
    assign armed    = (cnt >= duty_act[ARM_CH]);
    assign trig_acc = trig_edge && armed;

    opm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .brk(brk_i), .reload(reload),
        .trig_acc(trig_acc), .force_ovf(force_ovf), .cnt_q(cnt),
        .ovf_q(ovf_o), .restart(restart)
    );

    assign shadow_load = (restart && xfer_en) || force_upd;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            opm_chan #(.CNT_W(CNT_W)) u_chan (
                .clk(clk), .rst_n(rst_n), .brk(brk_i), .load(shadow_load),
                .duty_pre(duty_pre[ch]), .pol_pre(pol_pre[ch]), .cnt(cnt),
                .run(run), .opm_en(opm_en), .duty_act(duty_act[ch]),
                .pwm_o(pwm_o[ch])
            );
        end
    endgenerate

    assign cnt_o = cnt;
endmodule

// File: rtl/opm_pwm_timer_chk.sv
// Module: assertion checker for the one-pulse PWM timer, bound to the top.
module opm_pwm_timer_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             brk,
    input logic             run,
    input logic             restart,
    input logic             trig_acc,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             ovf
);
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !brk && cnt == reload) |=> (cnt == '0 && ovf));

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !brk && !restart) |=> (cnt == CNT_W'($past(cnt) + 1)));

    a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt == '0));

    a_r4_trig_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_acc && run && !brk) |=> (cnt == '0 && ovf));

    a_r10_break_clear: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> (cnt == '0 && !ovf && reload == '0));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !brk) |=> ($stable(cnt) && !ovf));
endmodule

bind opm_pwm_timer opm_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .brk(brk_i), .run(run), .restart(restart),
    .trig_acc(trig_acc), .cnt(cnt), .reload(reload), .ovf(ovf_o)
);

// File: tb/test_opm_pwm_timer.sv
module test_opm_pwm_timer;
    localparam int CLK_PERIOD = 10;
    localparam int A_RELOAD = 0, A_DUTY0 = 1, A_DUTY1 = 2, A_CTRL = 3, A_CMD = 4;

    typedef struct packed {
        logic [11:0] rl;
        logic [11:0] d0;
        logic [11:0] d1;
        int          hi0;
        int          hi1;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{12'd9,  12'd3,  12'd7, 3,  7},
        '{12'd4,  12'd0,  12'd5, 0,  5},
        '{12'd15, 12'd15, 12'd1, 15, 1},
        '{12'd0,  12'd1,  12'd0, 1,  0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        trig_i = 1'b0;
    logic        brk_i = 1'b0;
    logic [1:0]  pwm_o;
    logic        ovf_o;
    logic [11:0] cnt_o;

    int checks = 0;
    int failures = 0;

    opm_pwm_timer i_opm_pwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_i(trig_i), .brk_i(brk_i),
        .pwm_o(pwm_o), .ovf_o(ovf_o), .cnt_o(cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 12'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        while (int'(cnt_o) != v) @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int held;
        steps(3);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R3)
        chk(cnt_o == 0, "R1 reset cnt", cnt_o, 0);
        chk(ovf_o == 0, "R3 reset ovf", ovf_o, 0);
        chk(pwm_o == 0, "R11 reset pwm", pwm_o, 0);

        // Table walk: plain PWM, whole periods (R1, R2, R3)
        for (int r = 0; r < 4; r++) begin
            int h0, h1;
            h0 = 0; h1 = 0;
            wr(A_CTRL, 0);
            wr(A_RELOAD, ROWS[r].rl);
            wr(A_DUTY0, ROWS[r].d0);
            wr(A_DUTY1, ROWS[r].d1);
            wr(A_CTRL, 1);
            wr(A_CMD, 3);
            chk(cnt_o == 0 && ovf_o == 1, "R9 force restart", cnt_o, 0);
            for (int i = 0; i <= int'(ROWS[r].rl); i++) begin
                if (int'(cnt_o) != i) chk(0, "R1 count", cnt_o, i);
                if (pwm_o[0]) h0++;
                if (pwm_o[1]) h1++;
                @(negedge clk);
            end
            chk(cnt_o == 0 && ovf_o == 1, "R1 wrap", cnt_o, 0);
            chk(h0 == ROWS[r].hi0, "R2 high time ch0", h0, ROWS[r].hi0);
            chk(h1 == ROWS[r].hi1, "R2 high time ch1", h1, ROWS[r].hi1);
        end

        // One-pulse setup: reload 20, duty 5 / 8, rising edge, transfer on
        wr(A_RELOAD, 20); wr(A_DUTY0, 5); wr(A_DUTY1, 8);
        wr(A_CTRL, 15);
        wr(A_CMD, 3);
        chk(cnt_o == 0, "R9 restart", cnt_o, 0);
        trig_i = 1'b1;
        steps(3);
        chk(cnt_o == 3, "R5 early edge ignored", cnt_o, 3);
        wait_cnt(12);
        trig_i = 1'b0;
        steps(3);
        chk(cnt_o == 15, "R6 falling edge ignored", cnt_o, 15);
        trig_i = 1'b1;
        steps(3);
        chk(cnt_o == 0, "R4 trigger restart latency", cnt_o, 0);
        chk(ovf_o == 1, "R3 ovf on trigger", ovf_o, 1);
        chk(pwm_o == 2'b11, "R4 outputs high", pwm_o, 3);
        @(negedge clk);
        chk(ovf_o == 0, "R3 single-cycle ovf", ovf_o, 0);

        // Falling edge select (R6)
        wr(A_CTRL, 11);
        wait_cnt(10);
        trig_i = 1'b0;
        steps(3);
        chk(cnt_o == 0, "R6 falling edge restart", cnt_o, 0);

        // Polarity (R7)
        wr(A_CTRL, 27);
        wr(A_CMD, 1);
        wait_cnt(2);
        chk(pwm_o == 2'b10, "R7 inverted ch0", pwm_o, 2);
        wr(A_CTRL, 25);
        wait_cnt(2);
        chk(pwm_o[0] == 1, "R7 no inversion in PWM mode", pwm_o[0], 1);

        // Transfer gating (R8)
        wr(A_CTRL, 17);
        wr(A_DUTY0, 2);
        wait_cnt(20); wait_cnt(3);
        chk(pwm_o[0] == 1, "R8 duty held without transfer", pwm_o[0], 1);
        wr(A_CTRL, 25);
        wait_cnt(20); wait_cnt(3);
        chk(pwm_o[0] == 0, "R8 duty copied at restart", pwm_o[0], 0);

        // Forced overflow mid-period (R9)
        wait_cnt(7);
        wr(A_CMD, 2);
        chk(cnt_o == 0 && ovf_o == 1, "R9 forced overflow", cnt_o, 0);
        @(negedge clk);
        chk(cnt_o == 1 && ovf_o == 0, "R3 ovf one cycle", cnt_o, 1);

        // Stop (R11): one-pulse, active polarity ch0 = 1, ch1 = 0
        wr(A_CTRL, 18);
        held = int'(cnt_o);
        steps(2);
        chk(int'(cnt_o) == held && ovf_o == 0, "R11 counter held", cnt_o, held);
        chk(pwm_o == 2'b01, "R11 inactive levels", pwm_o, 1);

        // Break with simultaneous forced overflow (R10)
        wr(A_CTRL, 1);
        wr_en = 1'b1; wr_addr = 3'(A_CMD); wr_data = 12'd2; brk_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(cnt_o == 0 && ovf_o == 0, "R10 break beats force", ovf_o, 0);
        chk(pwm_o == 0, "R10 outputs inactive", pwm_o, 0);
        brk_i = 1'b0;
        @(negedge clk);
        chk(cnt_o == 0 && ovf_o == 1, "R10 reload cleared", cnt_o, 0);
        wr(A_CMD, 1);
        steps(2);
        chk(pwm_o == 0, "R10 duty cleared", pwm_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule